// File: doc/BRIEF.md
# Shadowed Four-Channel PWM Generator

This block produces four independent pulse-width-modulated outputs. Each channel counts prescaled ticks of a 1 MHz base tick, which arrives as a single-cycle enable on the system clock. Software programs a channel through three 32-bit registers: period length, high time and a control word that holds the prescaler select and the polarity. All of them are reached through a register port with one cycle of access.

Programming is atomic. Writes to the duty and control registers land in shadow copies only. A write to the period register arms a switch-over, and the armed channel loads every shadow field at once when its running period ends. A period of zero is a stop request: the channel finishes the running period, then parks its output low. A channel that is not running picks up a newly armed setting on the next base tick.

Top module: `shadow_pwm_top`

## Requirements
- R1: The synchronous active-low reset clears every register, so every register reads back as zero, and it drives all four outputs low.
- R2: Channel ch has its period register at byte address 0x400+4*ch, its duty register at 0x420+4*ch and its control register at 0x440+4*ch. A read returns the last written value of the implemented bits, with all other bits zero. The implemented bits are period [15:0], duty [15:0], and control bits [1:0] and bit 5. Read data appears one clock after rdEn.
- R3: A write to any other address changes no register and no output. A read from any other address returns zero.
- R4: With normal polarity (control bit 5 = 0), the output is high while the in-period count is below the duty value and low otherwise. The count starts at 0 when settings load and advances once per prescaled tick.
- R5: Control bits [1:0] select 1, 2, 4 or 8 base ticks per count step (codes 0 to 3). The prescaler restarts whenever new settings load.
- R6: Control bit 5 = 1 inverts the output level while the channel runs.
- R7: A duty value at or above the period keeps the output active for the whole period. A duty of 0 keeps it inactive for the whole period.
- R8: Duty and control writes have no effect on the output until the period register of that channel has also been written.
- R9: Once armed, a running channel loads all of its shadow fields together on the prescaled tick that ends its running period, and the next period starts at count 0.
- R10: A committed period of zero stops the channel after its running period. The output then stays low whatever the polarity setting.
- R11: A stopped or never-started channel loads an armed setting on the next base tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| baseTick | input | 1 | One-cycle 1 MHz tick enable |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 12 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| pwmOut | output | 4 | One PWM output per channel |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counts and a 12-bit address. This puts every channel's three registers, the unmapped gaps around them and all four prescaler codes within reach of short directed runs. Waveforms are kept to periods of two to five counts, so each run crosses several period boundaries. This lets the bench observe shadowed writes, commit points, stop requests and restarts from idle within a few dozen base ticks.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
  parameter int CNT_W = 16;
  parameter int DIV_W = 2;
  // prescaler counter wide enough for the largest divide ratio
  parameter int PRE_W = (1 << DIV_W) - 1;

  typedef struct packed {
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] duty;
    logic [DIV_W-1:0] divSel;
    logic             invert;
  } chanCfg_t;

  // strobes from control to datapath, one per channel
  typedef struct packed {
    logic     armed;
    chanCfg_t cfg;
  } chanStrobe_t;
endpackage

// File: rtl/shadow_pwm_ctrl.sv
module shadow_pwm_ctrl
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PER_BASE  = 'h400,
  parameter int DUTY_BASE = 'h420,
  parameter int CFG_BASE  = 'h440,
  parameter int INV_BIT   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CH-1:0] commitAck,
  output chanStrobe_t       strobe [NUM_CH]
);
  localparam int STRIDE = 4;

  chanCfg_t shadowVec [NUM_CH];
  logic [DATA_W-1:0] rdNext;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:CNT_W];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_reg
    localparam logic [ADDR_W-1:0] PER_ADDR  = ADDR_W'(PER_BASE + STRIDE * ch);
    localparam logic [ADDR_W-1:0] DUTY_ADDR = ADDR_W'(DUTY_BASE + STRIDE * ch);
    localparam logic [ADDR_W-1:0] CFG_ADDR  = ADDR_W'(CFG_BASE + STRIDE * ch);

    chanCfg_t shReg;
    logic     armReg;
    logic     perWr;

    assign perWr = wrEn && (addr == PER_ADDR);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shReg  <= '0;
        armReg <= 1'b0;
      end else begin
        if (perWr) shReg.period <= wrData[CNT_W-1:0];
        if (wrEn && (addr == DUTY_ADDR)) shReg.duty <= wrData[CNT_W-1:0];
        if (wrEn && (addr == CFG_ADDR)) begin
          shReg.divSel <= wrData[DIV_W-1:0];
          shReg.invert <= wrData[INV_BIT];
        end
        // a write in the commit cycle re-arms for the next boundary
        if (perWr)               armReg <= 1'b1;
        else if (commitAck[ch])  armReg <= 1'b0;
      end
    end

    assign shadowVec[ch] = shReg;
    assign strobe[ch]    = '{armed: armReg, cfg: shReg};
  end

  always_comb begin
    rdNext = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(PER_BASE + STRIDE * ch))
        rdNext[CNT_W-1:0] = shadowVec[ch].period;
      if (addr == ADDR_W'(DUTY_BASE + STRIDE * ch))
        rdNext[CNT_W-1:0] = shadowVec[ch].duty;
      if (addr == ADDR_W'(CFG_BASE + STRIDE * ch)) begin
        rdNext[DIV_W-1:0] = shadowVec[ch].divSel;
        rdNext[INV_BIT]   = shadowVec[ch].invert;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
    else           rdData <= '0;
  end
endmodule

// File: rtl/shadow_pwm_chan.sv
module shadow_pwm_chan
  import shadow_pwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        baseTick,
  input  chanStrobe_t strobe,
  output logic        commit,
  output logic        running,
  output logic        pwmOut
);
  chanCfg_t         act;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] divLast;
  logic             preWrap;
  logic             atEnd;

  assign divLast = PRE_W'((PRE_W'(1) << act.divSel) - PRE_W'(1));
  assign preWrap = baseTick && (pre == divLast);
  assign atEnd   = running && preWrap && (cnt == act.period - CNT_W'(1));
  assign commit  = strobe.armed && baseTick && (!running || atEnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      act     <= '0;
      cnt     <= '0;
      pre     <= '0;
      running <= 1'b0;
    end else if (commit) begin
      act     <= strobe.cfg;
      cnt     <= '0;
      pre     <= '0;
      running <= |strobe.cfg.period;
    end else if (running && baseTick) begin
      if (preWrap) begin
        pre <= '0;
        cnt <= atEnd ? '0 : cnt + CNT_W'(1);
      end else begin
        pre <= pre + PRE_W'(1);
      end
    end
  end

  always_comb pwmOut = running && ((cnt < act.duty) != act.invert);
endmodule

// File: rtl/shadow_pwm_dp.sv
module shadow_pwm_dp
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  chanStrobe_t       strobe [NUM_CH],
  output logic [NUM_CH-1:0] commitAck,
  output logic [NUM_CH-1:0] chRunning,
  output logic [NUM_CH-1:0] pwmOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    shadow_pwm_chan u_chan (
      .clk     (clk),
      .rstN    (rstN),
      .baseTick(baseTick),
      .strobe  (strobe[ch]),
      .commit  (commitAck[ch]),
      .running (chRunning[ch]),
      .pwmOut  (pwmOut[ch])
    );
  end
endmodule

// File: rtl/shadow_pwm_top.sv
module shadow_pwm_top
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PER_BASE  = 'h400,
  parameter int DUTY_BASE = 'h420,
  parameter int CFG_BASE  = 'h440
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baseTick,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanStrobe_t       strobe [NUM_CH];
  logic [NUM_CH-1:0] commitAck;
  logic [NUM_CH-1:0] chRunning;

  shadow_pwm_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PER_BASE(PER_BASE), .DUTY_BASE(DUTY_BASE), .CFG_BASE(CFG_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .commitAck(commitAck), .strobe(strobe)
  );

  shadow_pwm_dp #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .strobe(strobe),
    .commitAck(commitAck), .chRunning(chRunning), .pwmOut(pwmOut)
  );
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk
  import shadow_pwm_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PER_BASE  = 'h400,
  parameter int DUTY_BASE = 'h420,
  parameter int CFG_BASE  = 'h440
) (
  input logic              clk,
  input logic              rstN,
  input logic              baseTick,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] chRunning
);
  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (addr == ADDR_W'(PER_BASE + 4 * ch) || addr == ADDR_W'(DUTY_BASE + 4 * ch) ||
          addr == ADDR_W'(CFG_BASE + 4 * ch))
        mapped = 1'b1;
    end
  end

  // R1
  reset_out_low_chk: assert property (@(posedge clk) !rstN |=> (pwmOut == '0 && rdData == '0));

  // R3
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !mapped) |=> (rdData == '0));

  // R2
  period_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(PER_BASE)) |=> (rdData[DATA_W-1:CNT_W] == '0));

  // R8
  out_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baseTick |=> $stable(pwmOut));

  // R9
  run_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !baseTick |=> $stable(chRunning));
endmodule

bind shadow_pwm_top shadow_pwm_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .PER_BASE(PER_BASE), .DUTY_BASE(DUTY_BASE), .CFG_BASE(CFG_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .baseTick(baseTick), .rdEn(rdEn), .addr(addr),
  .rdData(rdData), .pwmOut(pwmOut), .chRunning(chRunning)
);

// File: tb/shadow_pwm_top_bench.sv
module shadow_pwm_top_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        baseTick = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  pwmOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  shadow_pwm_top u_shadow_pwm_top (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  function automatic logic [11:0] perA(int ch);  return 12'(12'h400 + 4 * ch); endfunction
  function automatic logic [11:0] dutyA(int ch); return 12'(12'h420 + 4 * ch); endfunction
  function automatic logic [11:0] cfgA(int ch);  return 12'(12'h440 + 4 * ch); endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk) rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic tickOnce();
    @(negedge clk) baseTick = 1'b1;
    @(negedge clk) baseTick = 1'b0;
  endtask

  task automatic tickCheck(input int ch, input bit exp, input string tag);
    tickOnce();
    check(tag, 32'(pwmOut[ch]), 32'(exp));
  endtask

  task automatic setup(input int ch, input logic [31:0] cfg, input logic [31:0] duty,
                       input logic [31:0] per);
    regWrite(cfgA(ch), cfg);
    regWrite(dutyA(ch), duty);
    regWrite(perA(ch), per);
  endtask

  // R1: reset clears registers and outputs after activity
  task automatic testReset();
    logic [31:0] d;
    setup(0, 32'h21, 32'd2, 32'd5);
    for (int k = 0; k < 3; k++) tickOnce();
    doReset();
    check("R1 outputs low", 32'(pwmOut), 32'h0);
    for (int ch = 0; ch < 4; ch++) begin
      regRead(perA(ch), d);  check("R1 period reg", d, 0);
      regRead(dutyA(ch), d); check("R1 duty reg", d, 0);
      regRead(cfgA(ch), d);  check("R1 control reg", d, 0);
    end
  endtask

  // R2 readback of implemented bits, R3 unmapped accesses
  task automatic testRegs();
    logic [31:0] d;
    doReset();
    regWrite(12'h460, 32'hFFFF_FFFF);
    regWrite(12'h402, 32'hFFFF_FFFF);
    regWrite(12'h000, 32'hFFFF_FFFF);
    regRead(12'h460, d); check("R3 read unmapped 0x460", d, 0);
    regRead(12'h402, d); check("R3 read unmapped 0x402", d, 0);
    for (int ch = 0; ch < 4; ch++) begin
      regRead(perA(ch), d);  check("R3 period untouched", d, 0);
      regRead(dutyA(ch), d); check("R3 duty untouched", d, 0);
      regRead(cfgA(ch), d);  check("R3 control untouched", d, 0);
    end
    tickOnce(); tickOnce();
    check("R3 outputs untouched", 32'(pwmOut), 32'h0);
    regWrite(cfgA(2), 32'hFFFF_FFFF);
    regWrite(dutyA(2), 32'hDEAD_BEEF);
    regWrite(perA(3), 32'h1234_5678);
    regRead(cfgA(2), d);  check("R2 control bits", d, 32'h23);
    regRead(dutyA(2), d); check("R2 duty bits", d, 32'hBEEF);
    regRead(perA(3), d);  check("R2 period bits", d, 32'h5678);
  endtask

  // R4 normal waveform, R11 start from idle on next base tick
  task automatic testNormal();
    doReset();
    setup(0, 32'h0, 32'd3, 32'd5);
    for (int k = 1; k <= 12; k++)
      tickCheck(0, ((k - 1) % 5) < 3, "R4 R11 normal waveform");
  endtask

  // R5 prescaler codes 2 and 3
  task automatic testPrescale();
    doReset();
    setup(1, 32'h2, 32'd1, 32'd3);
    for (int k = 1; k <= 24; k++)
      tickCheck(1, (((k - 1) / 4) % 3) < 1, "R5 divide by 4");
    doReset();
    setup(2, 32'h3, 32'd1, 32'd2);
    for (int k = 1; k <= 32; k++)
      tickCheck(2, (((k - 1) / 8) % 2) < 1, "R5 divide by 8");
  endtask

  // R6 inverted polarity
  task automatic testInvert();
    doReset();
    setup(2, 32'h20, 32'd1, 32'd4);
    for (int k = 1; k <= 8; k++)
      tickCheck(2, !(((k - 1) % 4) < 1), "R6 inverted waveform");
  endtask

  // R7 duty at or above period, then duty zero
  task automatic testDutyEdges();
    doReset();
    setup(3, 32'h0, 32'd5, 32'd3);
    for (int k = 1; k <= 3; k++) tickCheck(3, 1'b1, "R7 duty above period");
    regWrite(dutyA(3), 32'd0);
    regWrite(perA(3), 32'd3);
    for (int k = 4; k <= 9; k++) tickCheck(3, 1'b0, "R7 duty zero");
  endtask

  // R8 shadowing, R9 atomic switch at period end
  task automatic testShadow();
    logic [31:0] d;
    doReset();
    setup(0, 32'h0, 32'd1, 32'd4);
    for (int k = 1; k <= 6; k++) tickCheck(0, ((k - 1) % 4) < 1, "R8 before update");
    regWrite(dutyA(0), 32'd3);
    regWrite(cfgA(0), 32'h20);
    regRead(dutyA(0), d); check("R2 shadow readback", d, 32'd3);
    tickCheck(0, 1'b0, "R8 old settings kept");
    tickCheck(0, 1'b0, "R8 old settings kept");
    tickCheck(0, 1'b1, "R8 old settings after wrap");
    tickCheck(0, 1'b0, "R8 old settings kept");
    regWrite(perA(0), 32'd4);
    tickCheck(0, 1'b0, "R9 armed, period still running");
    tickCheck(0, 1'b0, "R9 armed, period still running");
    tickCheck(0, 1'b0, "R9 switch count 0");
    tickCheck(0, 1'b0, "R9 switch count 1");
    tickCheck(0, 1'b0, "R9 switch count 2");
    tickCheck(0, 1'b1, "R9 switch count 3 inverted");
  endtask

  // R10 stop after period with inverted polarity, R11 restart from idle
  task automatic testStop();
    doReset();
    setup(1, 32'h20, 32'd1, 32'd3);
    for (int k = 1; k <= 4; k++) tickCheck(1, !(((k - 1) % 3) < 1), "R10 before stop");
    regWrite(perA(1), 32'd0);
    tickCheck(1, 1'b1, "R10 period finishing");
    tickCheck(1, 1'b1, "R10 period finishing");
    for (int k = 7; k <= 11; k++) tickCheck(1, 1'b0, "R10 held low");
    regWrite(cfgA(1), 32'h0);
    regWrite(perA(1), 32'd2);
    tickCheck(1, 1'b1, "R11 restart count 0");
    tickCheck(1, 1'b0, "R11 restart count 1");
  endtask

  initial begin
    doReset();
    check("R1 outputs after reset", 32'(pwmOut), 32'h0);
    testReset();
    testRegs();
    testNormal();
    testPrescale();
    testInvert();
    testDutyEdges();
    testShadow();
    testStop();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule